// File: doc/BRIEF.md
# Cascade Extension Counter with Read Latch

This block widens a 16-bit position count by 8 bits. A lower quadrature counter emits a one-clock cascade pulse each time it wraps, together with a direction level. The block keeps an 8-bit upper count that steps once per cascade pulse, up or down as the direction level says, and wraps modulo 256 either way. It also takes the lower 16-bit value as an input.

A host reads the full value over an 8-bit bus as three bytes: the upper count first, then the high and low bytes of the lower word. The read begins on the clock edge at which the group select and the output enable are both sampled low. On that edge the block freezes the upper count and the lower word into a snapshot. The upper byte in the snapshot is the count from before any cascade pulse that arrives in that same cycle. That pulse still updates the live counter, so the three bytes always describe one position.

The read sequencer has four states. READ_IDLE waits for a start. SHIP_TOP, SHIP_MID and SHIP_BOT each present one byte. The transitions are:
- start: READ_IDLE to SHIP_TOP.
- advance: on each rising edge of the output enable, SHIP_TOP to SHIP_MID, SHIP_MID to SHIP_BOT, and SHIP_BOT back to READ_IDLE.
- abandon: from any shipping state to READ_IDLE when the select is sampled high.

The snapshot can only be taken again after the sequencer returns to READ_IDLE.

Top module: `cascade_ext_counter`

## Requirements
- R1: On a clock edge where `casc_pulse` is 1, the upper count increments when `casc_up` is 1 and decrements when it is 0. On an edge where `casc_pulse` is 0, the count is unchanged.
- R2: The upper count wraps modulo 256: counting up from FFh gives 00h, and counting down from 00h gives FFh.
- R3: A read starts on a clock edge in READ_IDLE where `sel_n` and `oe_n` are both 0. On that edge the snapshot takes the upper count as it was before that edge's pulse, and takes `lo_word` as it is.
- R4: A cascade pulse on the read-start edge is still counted by the upper counter. With a count of F0h counting up and `lo_word` at FFFFh, the read returns F0h, FFh, FFh, and the next read's upper byte is F1h.
- R5: While a read is in progress, cascade pulses and changes to `lo_word` do not change the bytes the read returns.
- R6: The bytes are returned in this order: snapshot upper count, `lo_word[15:8]`, then `lo_word[7:0]`. The sequencer moves to the next byte on a clock edge where `oe_n` is 1 and was 0 on the previous edge.
- R7: `dout` is 00h whenever `busy` is 0 or `oe_n` is 1. `busy` is 1 exactly when the sequencer is not in READ_IDLE.
- R8: If `sel_n` is sampled 1 during a read, the sequencer returns to READ_IDLE. The next start takes a new snapshot.
- R9: `oe_n` going low again inside a read does not take a new snapshot. Only a start from READ_IDLE does.
- R10: A synchronous reset (`rst` = 1) clears the count, the snapshot and the sequencer. After reset `busy` is 0 and the first read returns 00h as the upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| casc_pulse | input | 1 | One-cycle wrap pulse from the lower counter |
| casc_up | input | 1 | Direction of the pulse: 1 = up, 0 = down |
| lo_word | input | 16 | Current lower 16-bit count |
| sel_n | input | 1 | Group select for a multi-byte read, active low |
| oe_n | input | 1 | Output enable, active low; one low pulse per byte |
| dout | output | 8 | Byte presented to the host |
| busy | output | 1 | A multi-byte read is in progress |

## Verification
The upper byte appears on `dout` after the first clock edge following the read start. Each later byte appears after the edge where `oe_n` is sampled low again, following the previous advance edge. A cascade pulse is visible only in the upper byte of a later read. The bench therefore drives all inputs on falling edges, lets one rising edge pass, and samples on the next falling edge. Its model updates the expected count on the same step that drives the pulse, and it freezes the expected bytes on the step that drives the start.

// File: rtl/cxc_pkg.sv
package cxc_pkg;
    typedef enum logic [1:0] {
        READ_IDLE = 2'd0,
        SHIP_TOP  = 2'd1,
        SHIP_MID  = 2'd2,
        SHIP_BOT  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/cxc_updown_counter.sv
module cxc_updown_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step)
            count <= up ? count + ONE : count - ONE;
    end

    // R1: an up step moves the count forward by one (this also covers the R2 wrap)
    p_step_up_r1: assert property (@(posedge clk) disable iff (rst)
        (step && up) |=> (count == $past(count) + ONE));
    // R1: a down step moves the count back by one
    p_step_dn_r1: assert property (@(posedge clk) disable iff (rst)
        (step && !up) |=> (count == $past(count) - ONE));
    // R1: with no pulse the count stays where it is
    p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(count));
endmodule

// File: rtl/cxc_snapshot.sv
module cxc_snapshot #(
    parameter int CW = 8,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grab,
    input  logic [CW-1:0] cnt_in,
    input  logic [LW-1:0] lo_in,
    output logic [CW-1:0] top_q,
    output logic [LW-1:0] lo_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            lo_q  <= '0;
        end else if (grab) begin
            top_q <= cnt_in;
            lo_q  <= lo_in;
        end
    end

    // R3: a grab stores the count from before the pulse of that same edge
    p_grab_r3: assert property (@(posedge clk) disable iff (rst)
        grab |=> (top_q == $past(cnt_in)) && (lo_q == $past(lo_in)));
    // R5: without a grab the snapshot holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !grab |=> $stable(top_q) && $stable(lo_q));
endmodule

// File: rtl/cxc_read_fsm.sv
module cxc_read_fsm
    import cxc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_n,
    input  logic      oe_n,
    output logic      start,
    output logic      busy,
    output rd_state_e state
);
    rd_state_e nxt;
    logic      oe_q;
    logic      oe_rise;

    assign oe_rise = !oe_q && oe_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= READ_IDLE;
            oe_q  <= 1'b1;
        end else begin
            state <= nxt;
            oe_q  <= oe_n;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            READ_IDLE: if (!sel_n && !oe_n) nxt = SHIP_TOP;
            SHIP_TOP:  if (sel_n) nxt = READ_IDLE; else if (oe_rise) nxt = SHIP_MID;
            SHIP_MID:  if (sel_n) nxt = READ_IDLE; else if (oe_rise) nxt = SHIP_BOT;
            SHIP_BOT:  if (sel_n || oe_rise) nxt = READ_IDLE;
            default:   nxt = READ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start = 1'b0;
        busy  = 1'b1;
        unique case (state)
            READ_IDLE: begin
                busy  = 1'b0;
                start = !sel_n && !oe_n;
            end
            SHIP_TOP, SHIP_MID, SHIP_BOT: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // R6: the middle byte is reached only from the top byte
    p_order_mid_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SHIP_MID) |-> ($past(state) == SHIP_TOP || $past(state) == SHIP_MID));
    // R6: the bottom byte is reached only from the middle byte
    p_order_bot_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SHIP_BOT) |-> ($past(state) == SHIP_MID || $past(state) == SHIP_BOT));
    // R8: a high select during a read returns the sequencer to idle
    p_abandon_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && sel_n) |=> (state == READ_IDLE));
    // R9: no start is possible while a read is in progress
    p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);
endmodule

// File: rtl/cascade_ext_counter.sv
module cascade_ext_counter
    import cxc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LO_W  = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             casc_pulse,
    input  logic             casc_up,
    input  logic [LO_W-1:0]  lo_word,
    input  logic             sel_n,
    input  logic             oe_n,
    output logic [BUS_W-1:0] dout,
    output logic             busy
);
    localparam int LO_BYTES = LO_W / BUS_W;

    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] top_snap;
    logic [LO_W-1:0]  lo_snap;
    logic             start;
    rd_state_e        state;
    logic [BUS_W-1:0] lo_lane [LO_BYTES];

    cxc_updown_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .step(casc_pulse), .up(casc_up), .count(live_cnt)
    );

    cxc_snapshot #(.CW(CNT_W), .LW(LO_W)) u_snap (
        .clk(clk), .rst(rst), .grab(start), .cnt_in(live_cnt), .lo_in(lo_word),
        .top_q(top_snap), .lo_q(lo_snap)
    );

    cxc_read_fsm u_fsm (
        .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n),
        .start(start), .busy(busy), .state(state)
    );

    for (genvar g = 0; g < LO_BYTES; g++) begin : g_lane
        assign lo_lane[g] = lo_snap[g*BUS_W +: BUS_W];
    end

    always_comb begin
        dout = '0;
        if (!oe_n) begin
            unique case (state)
                SHIP_TOP:  dout = BUS_W'(top_snap);
                SHIP_MID:  dout = lo_lane[LO_BYTES-1];
                SHIP_BOT:  dout = lo_lane[0];
                default:   dout = '0;
            endcase
        end
    end

    // R7: the bus is quiet when the sequencer is idle
    p_quiet_bus_r7: assert property (@(posedge clk) disable iff (rst)
        (state == READ_IDLE) |-> (dout == '0));
    // R10: the cycle after a reset, no read is in progress
    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> !busy);
endmodule

// File: tb/cascade_ext_counter_tb_top.sv
module cascade_ext_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        casc_pulse = 1'b0;
    logic        casc_up = 1'b1;
    logic [15:0] lo_word = 16'h0000;
    logic        sel_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [7:0]  dout;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_cnt = 8'h00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cascade_ext_counter dut_i (
        .clk(clk), .rst(rst), .casc_pulse(casc_pulse), .casc_up(casc_up),
        .lo_word(lo_word), .sel_n(sel_n), .oe_n(oe_n), .dout(dout), .busy(busy)
    );

    function automatic logic [7:0] model_step(logic [7:0] c, bit p, bit u);
        if (!p) return c;
        return u ? c + 8'd1 : c - 8'd1;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_cnt(bit p, bit u);
        casc_pulse = p;
        casc_up    = u;
        exp_cnt    = model_step(exp_cnt, p, u);
    endtask

    task automatic rnd_cnt();
        drive_cnt(($urandom % 3) == 0, $urandom % 2);
    endtask

    // full three-byte read; the start edge carries pulse p/u
    task automatic do_read(bit p, bit u, bit abandon, bit noisy);
        logic [7:0] e_top, e_mid, e_bot;
        e_top = exp_cnt;
        e_mid = lo_word[15:8];
        e_bot = lo_word[7:0];
        sel_n = 1'b0;
        oe_n  = 1'b0;
        drive_cnt(p, u);
        tick();
        chk("R7 busy after start", {7'd0, busy}, 8'h01);
        chk("R3/R4/R6 upper byte", dout, e_top);
        if (abandon) begin
            drive_cnt(0, 0);
            sel_n = 1'b1;
            oe_n  = 1'b1;
            tick();
            chk("R8 abandon to idle", {7'd0, busy}, 8'h00);
            chk("R8 bus quiet after abandon", dout, 8'h00);
            return;
        end
        for (int k = 0; k < 2; k++) begin
            oe_n = 1'b1;
            if (noisy) begin rnd_cnt(); lo_word = 16'($urandom); end else drive_cnt(0, 0);
            tick();
            chk("R7 bus quiet with oe_n high", dout, 8'h00);
            oe_n = 1'b0;
            if (noisy) begin rnd_cnt(); lo_word = 16'($urandom); end else drive_cnt(0, 0);
            tick();
            chk("R5/R6/R9 lower byte", dout, (k == 0) ? e_mid : e_bot);
        end
        oe_n = 1'b1;
        drive_cnt(0, 0);
        tick();
        chk("R7 idle after last byte", {7'd0, busy}, 8'h00);
        chk("R7 bus quiet when idle", dout, 8'h00);
        sel_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        tick();
        tick();
        rst = 1'b0;
        tick();
        chk("R10 busy after reset", {7'd0, busy}, 8'h00);
        chk("R10 dout after reset", dout, 8'h00);
        lo_word = 16'hA55A;
        do_read(0, 0, 0, 0);                           // R10 upper byte 00

        // R2: wrap downward from 00
        drive_cnt(1, 0); tick(); drive_cnt(0, 0);
        do_read(0, 0, 0, 0);                           // expect FF
        // R2: wrap upward from FF
        drive_cnt(1, 1); tick(); drive_cnt(0, 0);
        do_read(0, 0, 0, 0);                           // expect 00

        // R4: coincident pulse at F0 / FFFF
        for (int i = 0; i < 240; i++) begin drive_cnt(1, 1); tick(); end
        drive_cnt(0, 0);
        lo_word = 16'hFFFF;
        do_read(1, 1, 0, 0);                           // F0, FF, FF
        lo_word = 16'h1234;
        do_read(0, 0, 0, 0);                           // R4 F1 counted

        // R8: abandon, then recapture
        lo_word = 16'h0F0F;
        do_read(1, 0, 1, 0);
        lo_word = 16'h7788;
        do_read(0, 0, 0, 1);

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            int gap = $urandom_range(0, 6);
            for (int g = 0; g < gap; g++) begin
                rnd_cnt();
                lo_word = 16'($urandom);
                tick();
            end
            drive_cnt(0, 0);
            do_read(($urandom % 2) == 1, $urandom % 2, ($urandom % 8) == 0, 1);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule